// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Unit

This block sits beside a CPU core and watches two streams: the address of each instruction the core is about to execute, and every access the core makes to its data spaces. A bank of program-address comparators and a smaller bank of data watchpoints are loaded through a simple register write port. When any enabled comparator matches, the block raises a halt request one cycle later and records which comparators fired in sticky hit vectors that software clears by writing a mask.

A watchpoint selects one of three data spaces: internal data memory, extended data memory or the special-register space. It can fire on reads, on writes or on both. It can also be made to fire only when the byte moved by the access equals a programmed value. Two activity outputs mirror, one cycle late, whether the core is executing and whether the debug side is performing an access.

Top module: `hw_break_unit`

## Requirements
- R1: Breakpoint `i` (config address `i`, `cfg_wdata[23:0]` = address, `cfg_wdata[31]` = enable) fires when it is enabled, `cpu_exec` is high and `cpu_pc` equals its address. No other condition makes it fire.
- R2: A breakpoint or watchpoint with its enable bit clear never sets a hit bit and never causes a halt, whatever its address and mode.
- R3: Watchpoint `j` is set through two registers. Its address register sits at config address `16+2j`, with `cfg_wdata[23:0]` = address and `cfg_wdata[31]` = enable. Its mode register sits at `17+2j`, with `[7:0]` = data value, `[8]` = write, `[9]` = read, `[10]` = data-match enable and `[12:11]` = space. With the write bit set, the watchpoint fires on a matching access that has `mem_wr`=1.
- R4: With the read bit set, a watchpoint fires on a matching access that has `mem_wr`=0. An access whose direction is not selected never fires it.
- R5: With data-match enable set, a watchpoint fires only when `mem_data` equals its data value, for reads and for writes. With data-match enable clear, the data value is ignored.
- R6: A watchpoint fires only when `mem_space` equals its space field. The encodings are 0 = internal data, 1 = extended data and 2 = special registers. Space 3 never matches.
- R7: `halt_req` is high in exactly the cycle after a cycle in which any enabled comparator matches, and low otherwise. Several matches in one cycle give the same single request.
- R8: A match sets its bit in `bp_hits` or `wp_hits` in the following cycle. Every comparator that matches in the same cycle has its bit set. A set bit stays set until it is cleared.
- R9: A write to config address 31 clears each `bp_hits` bit whose bit is set in `cfg_wdata[7:0]`, and each `wp_hits` bit whose bit is set in `cfg_wdata[15:8]`. A match in the same cycle keeps its bit set.
- R10: `code_run` equals `cpu_exec` delayed by one cycle, and `dbg_active` equals `dbg_access` delayed by one cycle.
- R11: After reset all comparators are disabled, and `halt_req`, the hit vectors and the activity outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 5 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| cpu_exec | input | 1 | Core is about to execute the instruction at cpu_pc |
| cpu_pc | input | 24 | Address of that instruction |
| mem_valid | input | 1 | Data access in this cycle |
| mem_wr | input | 1 | 1 = write, 0 = read |
| mem_space | input | 2 | Data space of the access |
| mem_addr | input | 24 | Access address |
| mem_data | input | 8 | Byte written or returned |
| dbg_access | input | 1 | Debug side is accessing the system |
| halt_req | output | 1 | Halt request, one cycle after a match |
| bp_hits | output | 8 | Sticky breakpoint hit bits |
| wp_hits | output | 4 | Sticky watchpoint hit bits |
| code_run | output | 1 | Registered execution indicator |
| dbg_active | output | 1 | Registered debug access indicator |

## Verification
A wrong comparator setting, such as an enable, a direction bit, the space or the data value, shows one cycle after the offending access: either a missing or extra `halt_req` pulse, or a wrong bit in the hit vectors. A wrong sticky state shows on the hit vectors in any later cycle, either as a bit that drops without a clear or as a bit that survives its clear. Each scenario therefore probes one access and checks the outputs in the cycle after it, and then again after an idle cycle.

// File: rtl/hw_break_unit.sv
module hw_break_unit #(
  parameter int NUM_BP = 8,
  parameter int NUM_WP = 4,
  parameter int AW     = 24,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cpu_exec,
  input  logic [AW-1:0]     cpu_pc,
  input  logic              mem_valid,
  input  logic              mem_wr,
  input  logic [1:0]        mem_space,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_data,
  input  logic              dbg_access,
  output logic              halt_req,
  output logic [NUM_BP-1:0] bp_hits,
  output logic [NUM_WP-1:0] wp_hits,
  output logic              code_run,
  output logic              dbg_active
);
  localparam int WP_BASE = 16;
  localparam logic [4:0] CLR_ADDR = 5'd31;
  localparam int EN_BIT = 31;

  logic [AW-1:0] bp_addr [NUM_BP];
  logic [NUM_BP-1:0] bp_en;
  logic [AW-1:0] wp_addr [NUM_WP];
  logic [DW-1:0] wp_val  [NUM_WP];
  logic [1:0]    wp_space[NUM_WP];
  logic [NUM_WP-1:0] wp_en, wp_wr, wp_rd, wp_dme;

  logic [NUM_BP-1:0] bp_match;
  logic [NUM_WP-1:0] wp_match;
  logic clr_wr;
  logic unused_cfg;

  assign clr_wr = cfg_we && (cfg_addr == CLR_ADDR);
  assign unused_cfg = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp_en <= '0;
      wp_en <= '0;
      wp_wr <= '0;
      wp_rd <= '0;
      wp_dme <= '0;
      for (int i = 0; i < NUM_BP; i++) bp_addr[i] <= '0;
      for (int j = 0; j < NUM_WP; j++) begin
        wp_addr[j]  <= '0;
        wp_val[j]   <= '0;
        wp_space[j] <= 2'd3;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BP; i++)
        if (cfg_addr == 5'(i)) begin
          bp_addr[i] <= cfg_wdata[AW-1:0];
          bp_en[i]   <= cfg_wdata[EN_BIT];
        end
      for (int j = 0; j < NUM_WP; j++) begin
        if (cfg_addr == 5'(WP_BASE + 2*j)) begin
          wp_addr[j] <= cfg_wdata[AW-1:0];
          wp_en[j]   <= cfg_wdata[EN_BIT];
        end
        if (cfg_addr == 5'(WP_BASE + 2*j + 1)) begin
          wp_val[j]   <= cfg_wdata[DW-1:0];
          wp_wr[j]    <= cfg_wdata[DW];
          wp_rd[j]    <= cfg_wdata[DW+1];
          wp_dme[j]   <= cfg_wdata[DW+2];
          wp_space[j] <= cfg_wdata[DW+4:DW+3];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BP; i++)
      bp_match[i] = bp_en[i] && cpu_exec && (cpu_pc == bp_addr[i]);
    for (int j = 0; j < NUM_WP; j++)
      wp_match[j] = wp_en[j] && mem_valid
                 && (wp_space[j] != 2'd3) && (mem_space == wp_space[j])
                 && (mem_wr ? wp_wr[j] : wp_rd[j])
                 && (!wp_dme[j] || (mem_data == wp_val[j]))
                 && (mem_addr == wp_addr[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_req   <= 1'b0;
      bp_hits    <= '0;
      wp_hits    <= '0;
      code_run   <= 1'b0;
      dbg_active <= 1'b0;
    end else begin
      halt_req   <= |{bp_match, wp_match};
      bp_hits    <= (clr_wr ? bp_hits & ~cfg_wdata[NUM_BP-1:0] : bp_hits) | bp_match;
      wp_hits    <= (clr_wr ? wp_hits & ~cfg_wdata[8 +: NUM_WP] : wp_hits) | wp_match;
      code_run   <= cpu_exec;
      dbg_active <= dbg_access;
    end
  end
endmodule

// File: rtl/hw_break_unit_chk.sv
module hw_break_unit_chk #(
  parameter int NUM_BP = 8,
  parameter int NUM_WP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [4:0]        cfg_addr,
  input logic [NUM_BP-1:0] bp_match,
  input logic [NUM_WP-1:0] wp_match,
  input logic              halt_req,
  input logic [NUM_BP-1:0] bp_hits,
  input logic [NUM_WP-1:0] wp_hits,
  input logic              cpu_exec,
  input logic              dbg_access,
  input logic              code_run,
  input logic              dbg_active
);
  logic clr;
  assign clr = cfg_we && (cfg_addr == 5'd31);

  a_r7_halt_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (|{bp_match, wp_match}) |=> halt_req);

  a_r7_no_spurious_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{bp_match, wp_match}) |=> !halt_req);

  a_r8_bp_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|bp_match) |=> ((bp_hits & $past(bp_match)) == $past(bp_match)));

  a_r8_wp_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|wp_match) |=> ((wp_hits & $past(wp_match)) == $past(wp_match)));

  a_r8_hits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((($past(bp_hits) & ~bp_hits) == '0) && (($past(wp_hits) & ~wp_hits) == '0)));

  a_r10_activity: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code_run == $past(cpu_exec)) && (dbg_active == $past(dbg_access)));
endmodule

bind hw_break_unit hw_break_unit_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .bp_match(bp_match), .wp_match(wp_match), .halt_req(halt_req),
  .bp_hits(bp_hits), .wp_hits(wp_hits), .cpu_exec(cpu_exec),
  .dbg_access(dbg_access), .code_run(code_run), .dbg_active(dbg_active)
);

// File: tb/hw_break_unit_bench.sv
`timescale 1ns/1ps
module hw_break_unit_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [4:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0;
  logic cpu_exec = 0; logic [23:0] cpu_pc = 0;
  logic mem_valid = 0, mem_wr = 0; logic [1:0] mem_space = 0;
  logic [23:0] mem_addr = 0; logic [7:0] mem_data = 0;
  logic dbg_access = 0;
  logic halt_req, code_run, dbg_active;
  logic [7:0] bp_hits; logic [3:0] wp_hits;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hw_break_unit u_hw_break_unit (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wp_cfg(int j, logic [23:0] a, logic [7:0] v,
                        bit wr, bit rd, bit dme, logic [1:0] sp);
    cfg(5'(16 + 2*j), {1'b1, 7'd0, a});
    cfg(5'(17 + 2*j), {19'd0, sp, dme, rd, wr, v});
  endtask

  task automatic exec_at(logic [23:0] pc);
    @(negedge clk); cpu_exec = 1; cpu_pc = pc;
    @(posedge clk); #1;
    @(negedge clk); cpu_exec = 0;
  endtask

  task automatic access(bit wr, logic [1:0] sp, logic [23:0] a, logic [7:0] d);
    @(negedge clk); mem_valid = 1; mem_wr = wr; mem_space = sp; mem_addr = a; mem_data = d;
    @(posedge clk); #1;
    @(negedge clk); mem_valid = 0;
  endtask

  task automatic clear_all();
    cfg(5'd31, 32'h0000_FFFF);
  endtask

  task automatic t_reset();
    check("R11 halt", halt_req, 0);
    check("R11 bp_hits", bp_hits, 0);
    check("R11 wp_hits", wp_hits, 0);
    check("R11 code_run", code_run, 0);
    exec_at(24'h0);
    check("R2 reset-disabled bp at 0", bp_hits, 0);
    check("R2 no halt", halt_req, 0);
  endtask

  task automatic t_pc_bp();
    cfg(5'd3, {1'b1, 7'd0, 24'h123456});
    exec_at(24'h123455);
    check("R1 near miss", bp_hits, 0);
    @(negedge clk); cpu_exec = 1; cpu_pc = 24'h123456;
    @(posedge clk); #1;
    check("R7 halt after hit", halt_req, 1);
    check("R1 bp3 hit", bp_hits, 8'h08);
    @(negedge clk); cpu_exec = 0;
    @(posedge clk); #1;
    check("R7 halt drops", halt_req, 0);
    check("R8 sticky hold", bp_hits, 8'h08);
    @(negedge clk); cpu_pc = 24'h123456;
    @(posedge clk); #1;
    check("R1 no exec no hit", halt_req, 0);
  endtask

  task automatic t_disabled();
    cfg(5'd5, {1'b0, 7'd0, 24'h000100});
    exec_at(24'h000100);
    check("R2 disabled bp5", bp_hits, 8'h08);
    check("R2 disabled no halt", halt_req, 0);
  endtask

  task automatic t_clear();
    cfg(5'd31, 32'h0000_0004);
    check("R9 unmasked kept", bp_hits, 8'h08);
    cfg(5'd31, 32'h0000_0008);
    check("R9 cleared", bp_hits, 8'h00);
  endtask

  task automatic t_multi();
    cfg(5'd0, {1'b1, 7'd0, 24'h004000});
    cfg(5'd1, {1'b1, 7'd0, 24'h004000});
    exec_at(24'h004000);
    check("R8 both set", bp_hits, 8'h03);
    check("R7 single halt", halt_req, 1);
    clear_all();
  endtask

  task automatic t_write_wp();
    wp_cfg(0, 24'h000045, 8'h00, 1, 0, 0, 2'd0);
    access(0, 2'd0, 24'h000045, 8'h11);
    check("R4 read ignored by write-only", wp_hits, 0);
    access(1, 2'd1, 24'h000045, 8'h11);
    check("R6 wrong space", wp_hits, 0);
    access(1, 2'd0, 24'h000046, 8'h11);
    check("R3 wrong address", wp_hits, 0);
    access(1, 2'd0, 24'h000045, 8'h11);
    check("R3 write hit", wp_hits, 4'h1);
    check("R7 halt on wp", halt_req, 1);
    clear_all();
  endtask

  task automatic t_read_wp();
    wp_cfg(1, 24'h008000, 8'h00, 0, 1, 0, 2'd1);
    access(1, 2'd1, 24'h008000, 8'h22);
    check("R3 write ignored by read-only", wp_hits, 0);
    access(0, 2'd1, 24'h008000, 8'h22);
    check("R4 read hit", wp_hits, 4'h2);
    clear_all();
  endtask

  task automatic t_data();
    wp_cfg(2, 24'h000090, 8'hA5, 1, 1, 1, 2'd2);
    access(1, 2'd2, 24'h000090, 8'h5A);
    check("R5 data mismatch", wp_hits, 0);
    access(1, 2'd2, 24'h000090, 8'hA5);
    check("R5 write data hit", wp_hits, 4'h4);
    clear_all();
    access(0, 2'd2, 24'h000090, 8'hA5);
    check("R5 read data hit", wp_hits, 4'h4);
    clear_all();
  endtask

  task automatic t_space3();
    wp_cfg(3, 24'h000010, 8'h00, 1, 1, 0, 2'd3);
    access(1, 2'd3, 24'h000010, 8'h00);
    check("R6 space 3 never", wp_hits, 0);
    check("R6 no halt", halt_req, 0);
  endtask

  task automatic t_set_beats_clear();
    @(negedge clk); cfg_we = 1; cfg_addr = 5'd31; cfg_wdata = 32'h0000_0001;
    cpu_exec = 1; cpu_pc = 24'h004000;
    @(posedge clk); #1;
    check("R9 set wins over clear", bp_hits, 8'h03);
    @(negedge clk); cfg_we = 0; cpu_exec = 0;
    clear_all();
    check("R9 all cleared", bp_hits, 0);
  endtask

  task automatic t_activity();
    @(negedge clk); cpu_pc = 24'hABCDEF; cpu_exec = 1; dbg_access = 0;
    @(posedge clk); #1;
    check("R10 code_run", code_run, 1);
    check("R10 dbg idle", dbg_active, 0);
    @(negedge clk); cpu_exec = 0; dbg_access = 1;
    @(posedge clk); #1;
    check("R10 code_run off", code_run, 0);
    check("R10 dbg_active", dbg_active, 1);
    @(negedge clk); dbg_access = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_pc_bp();
    t_disabled();
    t_clear();
    t_multi();
    t_write_wp();
    t_read_wp();
    t_data();
    t_space3();
    t_set_beats_clear();
    t_activity();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule